// File: doc/BRIEF.md
# CSMA/CD Deferral and Backoff Controller

This controller decides when a frame may go out on a shared half-duplex medium. The host raises a request. The controller then waits until carrier sense is quiet and times the interframe gap. When the gap is complete it sends a one-cycle start pulse to the framer. The framer does the serialisation and later reports either a collision or the end of the frame. All timing is counted in bit times, and a bit time is a clock cycle in which the bit-time enable input is high.

The interframe gap has two phases. Carrier activity during the first phase sends the controller back to deferral and restarts the gap. Once the first phase has elapsed, the controller ignores carrier and finishes the remaining bit times.

After a collision, the controller draws a backoff of r slot times, where r is a value taken from a free-running LFSR and masked to min(n, 10) bits, n being the number of collisions so far for this frame. After the backoff it defers and runs a new gap. On the sixteenth collision the frame is abandoned, and an excessive-collision pulse is raised.

Top module: `csma_defer_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `tx_start`, `tx_done` and `exc_col` are 0 and `attempt_cnt` is 0.
- R2: While `crs` is high the controller stays in deferral. When `crs` is sampled low in deferral, the gap begins at that edge, and `tx_start` rises IFG_TOTAL_BT bit-time edges later.
- R3: For a request in idle with the medium quiet and `bit_en` always high, `tx_start` is seen after clock edge IFG_TOTAL_BT+1, where edge 0 is the first edge with `tx_req` high (default gap 96 bit times).
- R4: `crs` sampled high on any of the first IFG_RESTART_BT counting edges of the gap (64 by default, the last one included) returns the controller to deferral. The full gap is then timed again after the carrier drops.
- R5: `crs` sampled high after the first IFG_RESTART_BT counting edges of the gap has no effect on when `tx_start` occurs.
- R6: Gap and backoff time advance only on cycles with `bit_en` high. With `bit_en` held low, no `tx_start` is issued.
- R7: After collision n, the delay from the collision edge to the next `tx_start` is r·SLOT_BT + 1 + IFG_TOTAL_BT cycles when `bit_en` is high, with 0 ≤ r < 2^min(n,10).
- R8: One backoff slot lasts SLOT_BT bit times (512 by default).
- R9: Each collision reported during a transmission that does not abort raises `attempt_cnt` by one. `attempt_cnt` never changes by any step other than +1 or a return to 0.
- R10: When a collision makes the collision count reach MAX_ATTEMPTS (16), `exc_col` pulses for one cycle, `attempt_cnt` returns to 0 and the controller goes idle.
- R11: `frm_end` during a transmission produces a one-cycle `tx_done` pulse and returns `attempt_cnt` to 0.
- R12: `tx_start`, `tx_done` and `exc_col` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | High for one cycle per bit time |
| tx_req | input | 1 | Host has a frame to send (level) |
| crs | input | 1 | Carrier sense from the medium |
| col | input | 1 | Collision notice from the framer during transmission |
| frm_end | input | 1 | Framer finished the frame without a collision |
| tx_start | output | 1 | One-cycle pulse: framer may begin transmitting |
| tx_done | output | 1 | One-cycle pulse: frame completed |
| exc_col | output | 1 | One-cycle pulse: frame abandoned after excessive collisions |
| attempt_cnt | output | $clog2(MAX_ATTEMPTS+1) | Collisions so far for the current frame |

## Verification
The bench places a single carrier pulse on every edge of the gap in turn. A design that moves the restart/commit boundary by one bit time starts early or late exactly at edge IFG_RESTART_BT, and a design that ignores the restart starts early for every pulse in the first phase. Each backoff delay is split arithmetically into a slot count and a remainder. A wrong slot length leaves a nonzero remainder, and a wrong exponent cap gives a count outside the allowed range. Full sixteen-collision sequences catch an abort one attempt too early or too late, or a count that is not cleared. A long stretch with `bit_en` low catches timers that run on the raw clock.

// File: rtl/csma_pkg.sv
package csma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_GAP1,
    ST_GAP2,
    ST_XMIT,
    ST_BACKOFF
  } csma_state_t;
endpackage

// File: rtl/csma_lfsr.sv
// Free-running Galois LFSR used as the backoff random source.
module csma_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)
      value <= SEED;
    else if (value[0])
      value <= (value >> 1) ^ TAPS;
    else
      value <= value >> 1;
  end
endmodule

// File: rtl/csma_gap_timer.sv
// Interframe gap counter: flags the end of the restartable phase and the end of the gap.
module csma_gap_timer #(
  parameter int IFG_RESTART_BT = 64,
  parameter int IFG_TOTAL_BT   = 96
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bit_en,
  output logic p1_hit,
  output logic expire
);
  localparam int CW = $clog2(IFG_TOTAL_BT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (bit_en)
      cnt <= cnt + 1'b1;
  end

  assign p1_hit = run && bit_en && (cnt == CW'(IFG_RESTART_BT - 1));
  assign expire = run && bit_en && (cnt == CW'(IFG_TOTAL_BT - 1));
endmodule

// File: rtl/csma_backoff.sv
// Draws a masked random slot count on load and times it out in bit times.
module csma_backoff #(
  parameter int LFSR_W = 16,
  parameter int SLOT_BT = 512,
  parameter int EXP_CAP = 10,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              load,
  input  logic [CNT_W-1:0]  n_coll,
  input  logic [LFSR_W-1:0] rnd,
  output logic              draw_zero,
  output logic              expire
);
  localparam int SW = (SLOT_BT > 1) ? $clog2(SLOT_BT) : 1;

  logic [EXP_CAP-1:0] fold, mask, draw, slots;
  logic [SW-1:0]      bt;

  // fold every LFSR bit onto the exponent width so no random bit goes unused
  always_comb begin
    fold = '0;
    for (int i = 0; i < LFSR_W; i++)
      fold[i % EXP_CAP] = fold[i % EXP_CAP] ^ rnd[i];
  end

  always_comb begin
    int k;
    k = (int'(n_coll) > EXP_CAP) ? EXP_CAP : int'(n_coll);
    for (int b = 0; b < EXP_CAP; b++)
      mask[b] = (b < k);
  end

  assign draw      = fold & mask;
  assign draw_zero = (draw == '0);
  assign expire    = bit_en && (slots == EXP_CAP'(1)) && (bt == SW'(SLOT_BT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slots <= '0;
      bt    <= '0;
    end else if (load) begin
      slots <= draw;
      bt    <= '0;
    end else if (slots != '0 && bit_en) begin
      if (bt == SW'(SLOT_BT - 1)) begin
        bt    <= '0;
        slots <= slots - 1'b1;
      end else begin
        bt <= bt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csma_defer_ctrl.sv
// Deferral, two-phase interframe gap, and truncated exponential backoff sequencing.
module csma_defer_ctrl #(
  parameter int IFG_RESTART_BT = 64,
  parameter int IFG_TOTAL_BT   = 96,
  parameter int SLOT_BT        = 512,
  parameter int EXP_CAP        = 10,
  parameter int MAX_ATTEMPTS   = 16,
  parameter int LFSR_W         = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic tx_req,
  input  logic crs,
  input  logic col,
  input  logic frm_end,
  output logic tx_start,
  output logic tx_done,
  output logic exc_col,
  output logic [$clog2(MAX_ATTEMPTS+1)-1:0] attempt_cnt
);
  import csma_pkg::*;

  localparam int AW = $clog2(MAX_ATTEMPTS + 1);

  csma_state_t     state, nxt;
  logic [LFSR_W-1:0] rnd;
  logic [AW-1:0]   n_next, att_d;
  logic            gap_run, p1_hit, gap_expire;
  logic            bo_load, bo_zero, bo_expire;
  logic            start_d, done_d, exc_d;

  csma_lfsr #(.W(LFSR_W)) lfsr_i (
    .clk(clk), .rst(rst), .value(rnd)
  );

  csma_gap_timer #(
    .IFG_RESTART_BT(IFG_RESTART_BT), .IFG_TOTAL_BT(IFG_TOTAL_BT)
  ) gap_i (
    .clk(clk), .rst(rst), .run(gap_run), .bit_en(bit_en),
    .p1_hit(p1_hit), .expire(gap_expire)
  );

  csma_backoff #(
    .LFSR_W(LFSR_W), .SLOT_BT(SLOT_BT), .EXP_CAP(EXP_CAP), .CNT_W(AW)
  ) bo_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .load(bo_load),
    .n_coll(n_next), .rnd(rnd), .draw_zero(bo_zero), .expire(bo_expire)
  );

  assign gap_run = (state == ST_GAP1) || (state == ST_GAP2);
  assign n_next  = attempt_cnt + 1'b1;

  always_comb begin
    nxt     = state;
    bo_load = 1'b0;
    start_d = 1'b0;
    done_d  = 1'b0;
    exc_d   = 1'b0;
    att_d   = attempt_cnt;
    case (state)
      ST_IDLE:  if (tx_req) nxt = ST_DEFER;
      ST_DEFER: if (!crs) nxt = ST_GAP1;
      ST_GAP1: begin
        if (crs)         nxt = ST_DEFER;
        else if (p1_hit) nxt = ST_GAP2;
      end
      ST_GAP2: begin
        if (gap_expire) begin
          nxt     = ST_XMIT;
          start_d = 1'b1;
        end
      end
      ST_XMIT: begin
        if (col) begin
          if (n_next == AW'(MAX_ATTEMPTS)) begin
            exc_d = 1'b1;
            att_d = '0;
            nxt   = ST_IDLE;
          end else begin
            att_d   = n_next;
            bo_load = 1'b1;
            nxt     = bo_zero ? ST_DEFER : ST_BACKOFF;
          end
        end else if (frm_end) begin
          done_d = 1'b1;
          att_d  = '0;
          nxt    = ST_IDLE;
        end
      end
      ST_BACKOFF: if (bo_expire) nxt = ST_DEFER;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      tx_start    <= 1'b0;
      tx_done     <= 1'b0;
      exc_col     <= 1'b0;
      attempt_cnt <= '0;
    end else begin
      state       <= nxt;
      tx_start    <= start_d;
      tx_done     <= done_d;
      exc_col     <= exc_d;
      attempt_cnt <= att_d;
    end
  end
endmodule

// File: rtl/csma_defer_ctrl_chk.sv
module csma_defer_ctrl_chk #(
  parameter int MAX_ATTEMPTS = 16
) (
  input logic clk,
  input logic rst,
  input logic col,
  input logic frm_end,
  input logic tx_start,
  input logic tx_done,
  input logic exc_col,
  input logic [$clog2(MAX_ATTEMPTS+1)-1:0] attempt_cnt
);
  assert_pulses_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_start, tx_done, exc_col}));

  assert_start_single_R12: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (rst)
    exc_col |-> (attempt_cnt == '0) && $past(col));

  assert_done_clears_R11: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (attempt_cnt == '0) && $past(frm_end));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    (attempt_cnt != $past(attempt_cnt)) |->
      ((attempt_cnt == $past(attempt_cnt) + 1'b1) || (attempt_cnt == '0)));

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    int'(attempt_cnt) < MAX_ATTEMPTS);
endmodule

bind csma_defer_ctrl csma_defer_ctrl_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) chk_i (
  .clk(clk), .rst(rst), .col(col), .frm_end(frm_end),
  .tx_start(tx_start), .tx_done(tx_done), .exc_col(exc_col),
  .attempt_cnt(attempt_cnt)
);

// File: tb/csma_defer_ctrl_tb_top.sv
module csma_defer_ctrl_tb_top;
  localparam int P1   = 8;
  localparam int TOT  = 12;
  localparam int SLOT = 4;
  localparam int CAP  = 10;
  localparam int MAXA = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, tx_req = 1'b0, crs = 1'b0, col = 1'b0, frm_end = 1'b0;
  logic tx_start, tx_done, exc_col;
  logic [$clog2(MAXA+1)-1:0] attempt_cnt;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  csma_defer_ctrl #(
    .IFG_RESTART_BT(P1), .IFG_TOTAL_BT(TOT), .SLOT_BT(SLOT),
    .EXP_CAP(CAP), .MAX_ATTEMPTS(MAXA)
  ) dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .tx_req(tx_req), .crs(crs),
    .col(col), .frm_end(frm_end), .tx_start(tx_start), .tx_done(tx_done),
    .exc_col(exc_col), .attempt_cnt(attempt_cnt)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Edge 0 is the first edge of the call. crs is high on edges lo..hi and col on edge 0 if asked.
  task automatic run_to_start(input int lo, input int hi, input bit col_first,
                              output int idx, output int att0);
    idx  = -1;
    att0 = -1;
    for (int i = 0; i < 20000; i++) begin
      crs = (i >= lo) && (i <= hi);
      col = col_first && (i == 0);
      @(posedge clk); #1;
      if (i == 0) att0 = int'(attempt_cnt);
      if (exc_col) begin idx = -2; break; end
      if (tx_start) begin idx = i; break; end
    end
    crs = 1'b0;
    col = 1'b0;
  endtask

  task automatic end_frame(input string tag);
    frm_end = 1'b1;
    tx_req  = 1'b0;
    @(posedge clk); #1;
    chk(tx_done == 1'b1, {tag, " R11 tx_done"}, int'(tx_done), 1);
    chk(attempt_cnt == 0, {tag, " R11 count cleared"}, int'(attempt_cnt), 0);
    frm_end = 1'b0;
    @(posedge clk); #1;
    chk(tx_done == 1'b0 && tx_start == 1'b0, {tag, " R12 single pulse"}, int'(tx_done), 0);
  endtask

  initial begin
    int idx, att0, exp_i, starts, d, r, lim;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk({tx_start, tx_done, exc_col} == 3'b000, "R1 pulses low in reset", int'({tx_start, tx_done, exc_col}), 0);
    chk(attempt_cnt == 0, "R1 count zero in reset", int'(attempt_cnt), 0);
    rst = 1'b0;
    bit_en = 1'b1;
    @(posedge clk); #1;
    chk({tx_start, tx_done, exc_col} == 3'b000, "R1 pulses low after reset", int'({tx_start, tx_done, exc_col}), 0);

    // R3: quiet medium
    tx_req = 1'b1;
    run_to_start(-5, -5, 1'b0, idx, att0);
    chk(idx == TOT + 1, "R3 gap length", idx, TOT + 1);
    end_frame("R3");

    // R2: long carrier
    tx_req = 1'b1;
    run_to_start(0, 40, 1'b0, idx, att0);
    chk(idx == 41 + TOT, "R2 defer on carrier", idx, 41 + TOT);
    end_frame("R2");

    // R4 / R5: one-edge carrier pulse swept across the gap
    for (int k = 1; k <= TOT + 1; k++) begin
      tx_req = 1'b1;
      run_to_start(k, k, 1'b0, idx, att0);
      exp_i = (k <= P1 + 1) ? (k + 1 + TOT) : (TOT + 1);
      if (k <= P1 + 1) chk(idx == exp_i, $sformatf("R4 restart pulse at edge %0d", k), idx, exp_i);
      else             chk(idx == exp_i, $sformatf("R5 ignored pulse at edge %0d", k), idx, exp_i);
      end_frame("R4R5");
    end

    // R5: carrier held high through the committed phase
    tx_req = 1'b1;
    run_to_start(P1 + 2, TOT + 6, 1'b0, idx, att0);
    chk(idx == TOT + 1, "R5 long carrier in committed phase", idx, TOT + 1);
    end_frame("R5");

    // R6: no time passes without bit_en
    bit_en = 1'b0;
    tx_req = 1'b1;
    starts = 0;
    for (int i = 0; i < 150; i++) begin
      @(posedge clk); #1;
      if (tx_start) starts++;
    end
    chk(starts == 0, "R6 no start without bit_en", starts, 0);
    bit_en = 1'b1;
    run_to_start(-5, -5, 1'b0, idx, att0);
    chk(idx == TOT - 1, "R6 gap counted from bit_en", idx, TOT - 1);
    end_frame("R6");

    // R7 / R8 / R9 / R10: full collision sequences
    for (int pkt = 0; pkt < 3; pkt++) begin
      tx_req = 1'b1;
      run_to_start(-5, -5, 1'b0, idx, att0);
      chk(idx == TOT + 1, "R3 first attempt gap", idx, TOT + 1);
      for (int n = 1; n <= MAXA; n++) begin
        run_to_start(-5, -5, 1'b1, idx, att0);
        if (n < MAXA) begin
          chk(att0 == n, $sformatf("R9 count after collision %0d", n), att0, n);
          d   = idx - 1 - TOT;
          r   = d / SLOT;
          lim = 1 << ((n < CAP) ? n : CAP);
          chk(idx >= 0 && d >= 0 && (d % SLOT) == 0, $sformatf("R8 slot multiple n=%0d", n), d, r * SLOT);
          chk(r < lim, $sformatf("R7 backoff range n=%0d", n), r, lim - 1);
        end else begin
          chk(idx == -2, "R10 abort on final collision", idx, -2);
          chk(attempt_cnt == 0, "R10 count cleared", int'(attempt_cnt), 0);
          tx_req = 1'b0;
          starts = 0;
          for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            if (tx_start || exc_col) starts++;
          end
          chk(starts == 0, "R10 idle after abort, R12 single pulse", starts, 0);
        end
      end
    end

    // R11: completion after some collisions
    tx_req = 1'b1;
    run_to_start(-5, -5, 1'b0, idx, att0);
    for (int n = 1; n <= 3; n++) begin
      run_to_start(-5, -5, 1'b1, idx, att0);
      chk(att0 == n, "R9 count before completion", att0, n);
    end
    end_frame("R11 after collisions");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule